// File: doc/BRIEF.md
# DS3 Nibble-Parallel Transmit Payload Port

This block is the system-facing payload entry of a DS3 transmit framer. Everything runs from one local bit clock at the DS3 line rate (44.736 MHz). From that clock the block makes a nibble clock for the upstream equipment, and it captures one 4-bit payload nibble per nibble-clock cycle. It turns each nibble into four serial payload bits. Those bits go to a frame assembler together with a flag that marks the overhead bit slots. The assembler fills the overhead slots itself.

The frame timing is slaved to an external reference. A rising edge on the reference input is synchronised into the bit-clock domain. The edge restarts frame generation from the first block of a frame, and any partial frame in progress is dropped. The nibble clock runs at a nominal quarter of the bit clock. At each overhead slot its high phase is stretched by one bit period, so the payload nibbles fill only the payload slots. A marker output is high for the single nibble-clock period in which the last nibble of the frame is captured. The upstream side uses this marker to align its data to the frame.

Top module: `ds3_nib_tx`

## Requirements
- R1: After reset and until the first frame reference edge takes effect, the nibble clock, payload bit, payload-enable, overhead flag and frame marker outputs are all low.
- R2: Once framing runs, the nibble clock is high for two bit periods and then low for two bit periods for each nibble. At an overhead slot the clock stays high for that extra slot, so the high phase that contains an overhead slot lasts three bit periods.
- R3: The nibble input is captured on the third rising bit-clock edge after the edge on which the nibble clock rose. Values present only on the first or second edge after the rise are not used.
- R4: The nibble captured in one nibble-clock period is sent in the four payload slots that begin at the next nibble-clock rise, most significant bit (bit 3) first. Payload-enable is high in exactly those slots.
- R5: A frame is 56 blocks of 85 bit slots, 4760 in all. Slot 0 of each block is an overhead slot: the overhead flag is high and payload-enable is low. Slots 1 to 84 are payload slots: payload-enable is high and the overhead flag is low. This gives 21 whole nibbles per block and 1176 per frame.
- R6: The reference input passes through two synchroniser flops. If it is first seen high at bit-clock edge n, the cycles after edges n+2 to n+6 form a lead-in in which payload-enable, the overhead flag and the marker stay low. The nibble clock is low after edge n+2 and rises after edge n+3. The nibble captured in that lead-in period is the first nibble of the frame. The overhead slot of block 0 follows edge n+7.
- R7: The frame marker is high for exactly one nibble-clock period per frame: payload slots 77 to 80 of block 55 (frame positions 4752 to 4755). That is the period in which the frame's 1176th nibble is captured.
- R8: A reference edge during a running frame abandons that frame. Bits not yet sent and nibbles not yet sent are discarded, and the restart then follows the same timing as R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local DS3 bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_ref_i | input | 1 | Frame reference; a rising edge restarts the frame |
| nib_i | input | 4 | Payload nibble from the system side |
| nib_clk_o | output | 1 | Nibble clock to the system side |
| last_nib_o | output | 1 | High during the period that captures the frame's final nibble |
| pay_bit_o | output | 1 | Serial payload bit |
| pay_en_o | output | 1 | Current slot carries a payload bit |
| oh_slot_o | output | 1 | Current slot is an overhead slot |

## Verification
The clocked properties assume that reference edges are separated by at least a few bit periods and that the reference stays high for longer than the synchroniser depth, so that each edge yields one restart pulse. The properties about nibble-clock phase length and overhead-to-payload sequencing are guarded against the restart pulse and the cycle after it, because a restart legally cuts a nibble period short. The stimulus holds the reference high for 30 bit periods per edge and spaces the edges more than a frame apart. It changes the nibble only at the first and second edges after each nibble-clock rise, so that a capture on any edge other than the third shows up as wrong data.

// File: rtl/ds3_nib_pkg.sv
package ds3_nib_pkg;

   // Default geometry of a DS3 frame as seen by the payload port
   localparam int DS3_NIB_W        = 4;
   localparam int DS3_NIBS_PER_BLK = 21;
   localparam int DS3_BLKS         = 56;
   localparam int DS3_SYNC_STAGES  = 2;
   localparam int DS3_SAMPLE_EDGE  = 3;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/ds3_nib_refsync.sv
module ds3_nib_refsync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic ref_i,
   output logic restart_o
);

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], ref_i};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign restart_o = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/ds3_nib_framepos.sv
module ds3_nib_framepos #(
   parameter int NIB_W        = 4,
   parameter int NIBS_PER_BLK = 21,
   parameter int BLKS         = 56
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic restart_i,
   output logic nclk_o,
   output logic oh_o,
   output logic pay_o,
   output logic last_nib_o,
   output logic load_o,
   output logic shift_o
);

   localparam int BLK_LEN = 1 + NIB_W * NIBS_PER_BLK;
   localparam int BP_W    = $clog2(BLK_LEN);
   localparam int BK_W    = (BLKS > 1) ? $clog2(BLKS) : 1;
   localparam int PH_W    = (NIB_W > 1) ? $clog2(NIB_W) : 1;

   localparam logic [BP_W-1:0] BP_LAST = BP_W'(BLK_LEN - 1);
   localparam logic [BP_W-1:0] BP_LEAD = BP_W'(BLK_LEN - NIB_W - 1);
   localparam logic [BP_W-1:0] BP_MKLO = BP_W'(BLK_LEN - 2 * NIB_W);
   localparam logic [BP_W-1:0] BP_MKHI = BP_W'(BLK_LEN - NIB_W - 1);
   localparam logic [BK_W-1:0] BK_LAST = BK_W'(BLKS - 1);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(NIB_W - 1);

   logic            run_q, lead_q;
   logic [BP_W-1:0] bpos_q;
   logic [BK_W-1:0] blk_q;
   logic [PH_W-1:0] ph_q;
   logic            slot_pay, active;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q  <= 1'b0;
         lead_q <= 1'b1;
         bpos_q <= BP_LEAD;
         blk_q  <= BK_LAST;
         ph_q   <= PH_LAST;
      end else if (restart_i) begin
         run_q  <= 1'b1;
         lead_q <= 1'b1;
         bpos_q <= BP_LEAD;
         blk_q  <= BK_LAST;
         ph_q   <= PH_LAST;
      end else if (run_q) begin
         if (bpos_q == BP_LAST) begin
            bpos_q <= '0;
            if (blk_q == BK_LAST) begin
               blk_q  <= '0;
               lead_q <= 1'b0;
            end else begin
               blk_q <= blk_q + BK_W'(1);
            end
         end else begin
            bpos_q <= bpos_q + BP_W'(1);
         end
         if (slot_pay) ph_q <= ph_q + PH_W'(1);
      end
   end

   assign slot_pay   = (bpos_q != '0);
   assign active     = run_q & ~lead_q;
   assign oh_o       = active & ~slot_pay;
   assign pay_o      = active & slot_pay;
   assign last_nib_o = active && (blk_q == BK_LAST) &&
                       (bpos_q >= BP_MKLO) && (bpos_q <= BP_MKHI);
   assign nclk_o     = run_q & ~ph_q[PH_W-1];
   assign load_o     = ~slot_pay | ((ph_q == PH_LAST) && (bpos_q != BP_LAST));
   assign shift_o    = slot_pay;

endmodule

// File: rtl/ds3_nib_sampler.sv
module ds3_nib_sampler #(
   parameter int NIB_W       = 4,
   parameter int SAMPLE_EDGE = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             nclk_i,
   input  logic [NIB_W-1:0] nib_i,
   output logic [NIB_W-1:0] hold_o
);

   localparam int AGE_W = $clog2(SAMPLE_EDGE + 1);
   localparam logic [AGE_W-1:0] AGE_SAT = AGE_W'(SAMPLE_EDGE);

   logic             prev_q, rise, samp;
   logic [AGE_W-1:0] age_q;

   assign rise = nclk_i & ~prev_q;

   generate
      if (SAMPLE_EDGE == 1) begin : g_first_edge
         assign samp = rise;
      end else begin : g_later_edge
         assign samp = ~rise && (age_q == AGE_W'(SAMPLE_EDGE - 1));
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q <= 1'b0;
         age_q  <= AGE_SAT;
         hold_o <= '0;
      end else begin
         prev_q <= nclk_i;
         if (rise)                 age_q <= AGE_W'(1);
         else if (age_q != AGE_SAT) age_q <= age_q + AGE_W'(1);
         if (samp) hold_o <= nib_i;
      end
   end

endmodule

// File: rtl/ds3_nib_ser.sv
module ds3_nib_ser #(
   parameter int NIB_W = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic             shift_i,
   input  logic [NIB_W-1:0] hold_i,
   output logic             bit_o
);

   logic [NIB_W-1:0] sh_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      sh_q <= '0;
      else if (load_i)  sh_q <= hold_i;
      else if (shift_i) sh_q <= {sh_q[NIB_W-2:0], 1'b0};
   end

   assign bit_o = sh_q[NIB_W-1];

endmodule

// File: rtl/ds3_nib_tx.sv
module ds3_nib_tx
   import ds3_nib_pkg::*;
#(
   parameter int NIB_W        = DS3_NIB_W,
   parameter int NIBS_PER_BLK = DS3_NIBS_PER_BLK,
   parameter int BLKS         = DS3_BLKS,
   parameter int SYNC_STAGES  = DS3_SYNC_STAGES,
   parameter int SAMPLE_EDGE  = DS3_SAMPLE_EDGE
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             frame_ref_i,
   input  logic [NIB_W-1:0] nib_i,
   output logic             nib_clk_o,
   output logic             last_nib_o,
   output logic             pay_bit_o,
   output logic             pay_en_o,
   output logic             oh_slot_o
);

   // Elaboration-time parameter checks
   if (!is_pow2(NIB_W) || NIB_W < 2) begin : g_bad_nib_w
      $error("NIB_W must be a power of two of at least 2");
   end
   if (SAMPLE_EDGE < 1 || SAMPLE_EDGE > NIB_W - 1) begin : g_bad_edge
      $error("SAMPLE_EDGE must fall inside one nibble period");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (NIBS_PER_BLK < 2 || BLKS < 1) begin : g_bad_geom
      $error("frame geometry too small");
   end

   logic             restart;
   logic             load, shift, pay, ser_bit;
   logic [NIB_W-1:0] hold;

   ds3_nib_refsync #(.STAGES(SYNC_STAGES)) u_ref (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ref_i     (frame_ref_i),
      .restart_o (restart)
   );

   ds3_nib_framepos #(
      .NIB_W        (NIB_W),
      .NIBS_PER_BLK (NIBS_PER_BLK),
      .BLKS         (BLKS)
   ) u_pos (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .restart_i  (restart),
      .nclk_o     (nib_clk_o),
      .oh_o       (oh_slot_o),
      .pay_o      (pay),
      .last_nib_o (last_nib_o),
      .load_o     (load),
      .shift_o    (shift)
   );

   ds3_nib_sampler #(.NIB_W(NIB_W), .SAMPLE_EDGE(SAMPLE_EDGE)) u_smp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .nclk_i (nib_clk_o),
      .nib_i  (nib_i),
      .hold_o (hold)
   );

   ds3_nib_ser #(.NIB_W(NIB_W)) u_ser (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (load),
      .shift_i (shift),
      .hold_i  (hold),
      .bit_o   (ser_bit)
   );

   assign pay_en_o  = pay;
   assign pay_bit_o = ser_bit & pay;

endmodule

// File: rtl/ds3_nib_tx_chk.sv
module ds3_nib_tx_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic restart_i,
   input logic nclk_i,
   input logic oh_i,
   input logic pay_i,
   input logic last_i
);

   // R2
   nclk_high_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(nclk_i) && !restart_i) |=> nclk_i);

   // R2
   nclk_low_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(nclk_i) && !restart_i && !$past(restart_i)) |=> !nclk_i);

   // R2
   oh_clk_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      oh_i |-> nclk_i);

   // R5
   oh_then_pay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (oh_i && !restart_i) |=> (pay_i && !oh_i));

   // R7
   marker_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(last_i) |-> $rose(nclk_i));

   // R5
   slot_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(oh_i && pay_i));

endmodule

bind ds3_nib_tx ds3_nib_tx_chk u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .restart_i (restart),
   .nclk_i    (nib_clk_o),
   .oh_i      (oh_slot_o),
   .pay_i     (pay_en_o),
   .last_i    (last_nib_o)
);

// File: tb/ds3_nib_tx_tb.sv
module ds3_nib_tx_tb;

   localparam int CLK_PERIOD = 10;
   localparam int BLK_LEN    = 85;
   localparam int FRM_LEN    = 4760;
   localparam int WATCHDOG   = 100000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fref = 1'b0;
   logic [3:0] nib = 4'h0;
   logic       nclk, last_nib, pbit, pen, oh;

   ds3_nib_tx u_dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .frame_ref_i (fref),
      .nib_i       (nib),
      .nib_clk_o   (nclk),
      .last_nib_o  (last_nib),
      .pay_bit_o   (pbit),
      .pay_en_o    (pen),
      .oh_slot_o   (oh)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int  n_chk = 0, n_fail = 0;
   bit  done = 1'b0;
   int  flush_cyc = -1;

   logic [3:0] expq[$];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
      end
   endtask

   function automatic logic [3:0] pat(input int i);
      return 4'((i * 7 + 3) ^ (i >> 3));
   endfunction

   // Driver, scoreboard flush and monitor in one ordered process
   bit         synced = 1'b0;
   int         pos = 0, bits = 0, dcnt = 3, idx = 0;
   logic [3:0] acc = 4'h0, real_nib = 4'h0;
   logic       prev_nclk = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         // driver: decoy at rise, true nibble after the second edge (R3)
         if (nclk && !prev_nclk) begin
            dcnt = 0;
            idx++;
            real_nib = pat(idx);
            nib <= ~real_nib;
         end else if (dcnt < 3) begin
            dcnt++;
            if (dcnt == 2) begin
               nib <= real_nib;
               expq.push_back(real_nib);
            end
         end
         prev_nclk = nclk;

         // restart takes effect here: drop pending work (R6, R8)
         if (cyc == flush_cyc) begin
            expq.delete();
            bits   = 0;
            pos    = -6;
            synced = 1'b1;
         end

         if (!synced) begin
            // R1: idle before the first reference edge
            chk(!nclk && !pen && !oh && !last_nib && !pbit, "R1",
                {nclk, pen, oh, last_nib, pbit}, 0);
         end else begin
            pos++;
            if (pos < 0) begin
               // R6: lead-in
               chk(!pen && !oh && !last_nib, "R6", {pen, oh, last_nib}, 0);
               chk(nclk == (pos == -4 || pos == -3), "R6", nclk, (pos == -4 || pos == -3));
            end else begin
               automatic int  b    = pos % BLK_LEN;
               automatic int  fp   = pos % FRM_LEN;
               automatic bit  e_oh = (b == 0);
               automatic bit  e_ck = (b == 0) ? 1'b1 : (((b - 1) % 4) < 2);
               automatic bit  e_mk = (fp >= 4752 && fp <= 4755);
               chk(oh == e_oh && pen == !e_oh, "R5", {oh, pen}, {e_oh, !e_oh});
               chk(nclk == e_ck, "R2", nclk, e_ck);
               chk(last_nib == e_mk, "R7", last_nib, e_mk);
               if (pen) begin
                  acc = {acc[2:0], pbit};
                  bits++;
                  if (bits == 4) begin
                     bits = 0;
                     if (expq.size() == 0) begin
                        chk(1'b0, "R4", acc, -1);
                     end else begin
                        automatic logic [3:0] e = expq.pop_front();
                        // R3 and R4: captured value, MSB first
                        chk(acc == e, "R3/R4", acc, e);
                     end
                  end
               end
            end
         end
      end
   end

   task automatic ref_edge();
      @(negedge clk);
      fref      = 1'b1;
      flush_cyc = cyc + 3;
      repeat (30) @(negedge clk);
      fref = 1'b0;
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (60) @(negedge clk);
      ref_edge();
      // two full frames and part of a third
      repeat (2 * FRM_LEN + 1300) @(negedge clk);
      // R8: restart in the middle of a frame
      ref_edge();
      repeat (FRM_LEN + 700) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, WATCHDOG);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule